// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable, small-depth memory with a synchronous control interface and an unregistered read path. On each rising clock edge it captures the address, the write data, three chip selects, two burst-start strobes, a step input and the write controls. Either strobe loads the external address. After that, a 2-bit counter produces each following word address inside the aligned group of four. The counter moves only in cycles where the step input is asserted. A static mode input picks the order: linear (wrap-around addition) or interleaved (XOR with the count).

Writes can cover any chosen subset of byte lanes, or every lane at once through an all-lane write control. Read data for the address captured on an edge is driven in that same cycle, with no pipeline register. The output drive is gated without a clock by an output enable and by a sleep input. While sleep is high, no access takes place and the contents are kept.

The controller is a four-state machine:
- IDLE: deselected.
- READ: the data bus is driven if the output enable allows.
- WRITE: the data bus is released.
- SLEEP: low-power hold.

Transitions:
- Any state goes to SLEEP whenever sleep is sampled high.
- A strobe that finds the device selected goes to READ or WRITE and loads the address.
- A strobe that finds it deselected goes to IDLE.
- With no strobe, READ and WRITE continue into READ or WRITE, chosen by that cycle's write controls.
- With no strobe, IDLE and SLEEP fall to IDLE.

Top module: `fsram_burst`

## Requirements
- R1: The device is selected only when cs1_n=0, cs2=1 and cs3_n=0. A strobe that starts while it is not selected moves it to IDLE, and dq_oe is then 0.
- R2: start_host_n=0 together with cs1_n=0 starts a read burst at addr with count 0. start_host_n is ignored while cs1_n=1, so an active burst continues as if no strobe were present.
- R3: start_ctrl_n=0 on a selected device starts a burst at addr with count 0. The cycle is a write when all_wr_n=0, or when lane_wr_n=0 with at least one lane_sel_n bit at 0. Otherwise it is a read. The write data dq_i is stored at the same edge.
- R4: When both strobes are asserted and cs1_n=0, the host strobe wins: the cycle is a read and nothing is written.
- R5: With neither strobe active during a burst, the 2-bit count increments (mod 4) only when step_n=0. The upper address bits stay at the loaded value.
- R6: With order_lin=1, the low two address bits are (start + count) mod 4.
- R7: With order_lin=0, the low two address bits are start XOR count.
- R8: When lane_wr_n=0 and all_wr_n=1, lane i (dq bits 8i+7..8i) is written exactly when lane_sel_n[i]=0. Other lanes keep their contents.
- R9: all_wr_n=0 writes all lanes, whatever lane_wr_n and lane_sel_n are.
- R10: Read data for the address captured on an edge appears on dq_o in that same cycle. A new address may be given on every cycle without a stall.
- R11: dq_oe=1 only in a READ cycle. It goes to 0 without waiting for a clock whenever oe_n=1.
- R12: While sleep=1, dq_oe is 0 at once and no write or read takes place. The contents are kept, and the next cycle with sleep=0 and no strobe leaves the device IDLE.
- R13: During and right after reset the state is IDLE and dq_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | AW | Word address sampled on a strobe |
| dq_i | input | NB*LW | Write data |
| dq_o | output | NB*LW | Read data (flow-through) |
| dq_oe | output | 1 | Output drive enable; 0 means high impedance |
| cs1_n | input | 1 | Chip select 1, active low; also gates the host strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| start_host_n | input | 1 | Host burst-start strobe (always a read), active low |
| start_ctrl_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst counter advance, active low |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| all_wr_n | input | 1 | All-lane write, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | NB | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Sleep request, asynchronous, active high |

## Verification
The bench builds the block with AW=4, NB=4 and LW=8: a 16-word memory made of four aligned burst groups with four 8-bit lanes. With this size the bench can fill and read back the whole array and try all sixteen lane-select patterns on separate words. It can run both burst orders from an odd start offset, where linear and interleaved order give different sequences. A reference array in the bench predicts every output cycle, including stalled counts, strobe priority and sleep.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } fs_state_e;

    localparam int BURST_BITS = 2;

    // Low address bits of a burst beat: linear adds, interleaved XORs.
    function automatic logic [BURST_BITS-1:0] burst_lo(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] cnt,
        input logic                  lin
    );
        logic [BURST_BITS-1:0] sum;
        sum = start + cnt;
        return lin ? sum : (start ^ cnt);
    endfunction

endpackage

// File: rtl/fsram_array.sv
module fsram_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic [NB-1:0]    wr_mask,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB*LW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*LW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[g]) begin
                mem[wr_addr] <= wr_data[g*LW +: LW];
            end
        end

        assign rd_data[g*LW +: LW] = mem[rd_addr];
    end

endmodule

// File: rtl/fsram_ctl.sv
module fsram_ctl
    import fsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          start_host_n,
    input  logic          start_ctrl_n,
    input  logic          step_n,
    input  logic          order_lin,
    input  logic          all_wr_n,
    input  logic          lane_wr_n,
    input  logic [NB-1:0] lane_sel_n,
    input  logic          sleep,
    output fs_state_e     st_q,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] wr_addr,
    output logic [NB-1:0] wr_mask
);
    localparam int HI_W = AW - BURST_BITS;

    fs_state_e             st_d;
    logic [AW-1:0]         base_q, base_d;
    logic [BURST_BITS-1:0] cnt_q, cnt_d;
    logic                  sel_ok, host_go, ctrl_go, wr_req, do_wr;
    logic [NB-1:0]         lane_pick;

    assign sel_ok  = !cs1_n && cs2 && !cs3_n;
    assign host_go = !start_host_n && !cs1_n;
    assign ctrl_go = !start_ctrl_n && !host_go;
    assign wr_req  = !all_wr_n || (!lane_wr_n && (lane_sel_n != '1));

    always_comb begin
        if (!all_wr_n)      lane_pick = '1;
        else if (!lane_wr_n) lane_pick = ~lane_sel_n;
        else                lane_pick = '0;
    end

    // Next-state and burst address logic.
    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        do_wr  = 1'b0;
        if (sleep) begin
            st_d = ST_SLEEP;
        end else if (host_go) begin
            if (sel_ok) begin
                st_d   = ST_READ;
                base_d = addr;
                cnt_d  = '0;
            end else begin
                st_d = ST_IDLE;
            end
        end else if (ctrl_go) begin
            if (sel_ok) begin
                st_d   = wr_req ? ST_WRITE : ST_READ;
                base_d = addr;
                cnt_d  = '0;
                do_wr  = wr_req;
            end else begin
                st_d = ST_IDLE;
            end
        end else begin
            unique case (st_q)
                ST_READ, ST_WRITE: begin
                    cnt_d = cnt_q + {{(BURST_BITS-1){1'b0}}, ~step_n};
                    st_d  = wr_req ? ST_WRITE : ST_READ;
                    do_wr = wr_req;
                end
                ST_IDLE, ST_SLEEP: st_d = ST_IDLE;
                default:           st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    // Address and write-mask outputs.
    always_comb begin
        cur_addr = {base_q[AW-1 -: HI_W], burst_lo(base_q[BURST_BITS-1:0], cnt_q, order_lin)};
        wr_addr  = {base_d[AW-1 -: HI_W], burst_lo(base_d[BURST_BITS-1:0], cnt_d, order_lin)};
        wr_mask  = do_wr ? lane_pick : '0;
    end

    a_r2_host_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && host_go && sel_ok) |=> (st_q == ST_READ && cnt_q == '0 && cur_addr == $past(addr)));

    a_r4_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_host_n && !start_ctrl_n && !cs1_n) |-> (wr_mask == '0));

    a_r5_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !host_go && ctrl_go == 1'b0 && (st_q == ST_READ || st_q == ST_WRITE) && step_n)
        |=> $stable(cnt_q));

    a_r9_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask != '0 && !all_wr_n) |-> (wr_mask == '1));

    a_r12_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (wr_mask == '0));

endmodule

// File: rtl/fsram_burst.sv
module fsram_burst
    import fsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [NB*LW-1:0] dq_i,
    output logic [NB*LW-1:0] dq_o,
    output logic             dq_oe,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             start_host_n,
    input  logic             start_ctrl_n,
    input  logic             step_n,
    input  logic             order_lin,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [NB-1:0]    lane_sel_n,
    input  logic             oe_n,
    input  logic             sleep
);
    fs_state_e     st;
    logic [AW-1:0] cur_addr, wr_addr;
    logic [NB-1:0] wr_mask;

    fsram_ctl #(.AW(AW), .NB(NB)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .cs1_n        (cs1_n),
        .cs2          (cs2),
        .cs3_n        (cs3_n),
        .start_host_n (start_host_n),
        .start_ctrl_n (start_ctrl_n),
        .step_n       (step_n),
        .order_lin    (order_lin),
        .all_wr_n     (all_wr_n),
        .lane_wr_n    (lane_wr_n),
        .lane_sel_n   (lane_sel_n),
        .sleep        (sleep),
        .st_q         (st),
        .cur_addr     (cur_addr),
        .wr_addr      (wr_addr),
        .wr_mask      (wr_mask)
    );

    fsram_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
        .clk     (clk),
        .wr_mask (wr_mask),
        .wr_addr (wr_addr),
        .wr_data (dq_i),
        .rd_addr (cur_addr),
        .rd_data (dq_o)
    );

    // Output drive: flow-through, gated asynchronously.
    always_comb begin
        dq_oe = (st == ST_READ) && !oe_n && !sleep;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !dq_oe);

    a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    a_r12_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

endmodule

// File: tb/fsram_burst_bench.sv
`timescale 1ns/1ps
module fsram_burst_bench;
    localparam int AW = 4;
    localparam int NB = 4;
    localparam int LW = 8;
    localparam int DW = NB * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic dq_oe;
    logic cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic start_host_n = 1'b1, start_ctrl_n = 1'b1, step_n = 1'b1;
    logic order_lin = 1'b1, all_wr_n = 1'b1, lane_wr_n = 1'b1;
    logic [NB-1:0] lane_sel_n = '1;
    logic oe_n = 1'b0, sleep = 1'b0;

    always #2.5 clk = ~clk;

    fsram_burst #(.AW(AW), .NB(NB), .LW(LW)) u_fsram_burst (
        .clk(clk), .rst_n(rst_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .start_host_n(start_host_n),
        .start_ctrl_n(start_ctrl_n), .step_n(step_n), .order_lin(order_lin),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .oe_n(oe_n), .sleep(sleep)
    );

    typedef struct {
        logic          oe;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state.
    logic [DW-1:0] rmem [DEPTH];
    int            m_st = 0;   // 0 idle, 1 read, 2 write, 3 sleep
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start_host_n = 1'b1; start_ctrl_n = 1'b1; step_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = '1;
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    endtask

    // Driver: predicts this cycle, queues the expectation, clocks once.
    task automatic tick(input string tag);
        bit host, ctrl, sel, wr;
        logic [NB-1:0] mask;
        logic [1:0] lo;
        logic [AW-1:0] a;
        exp_t e;
        host = !start_host_n && !cs1_n;
        ctrl = !start_ctrl_n && !host;
        sel  = !cs1_n && cs2 && !cs3_n;
        wr   = !all_wr_n || (!lane_wr_n && lane_sel_n != '1);
        mask = !all_wr_n ? '1 : (!lane_wr_n ? ~lane_sel_n : '0);
        if (sleep) begin
            m_st = 3; mask = '0;
        end else if (host) begin
            mask = '0;
            if (sel) begin m_st = 1; m_base = addr; m_cnt = 0; end else m_st = 0;
        end else if (ctrl) begin
            if (sel) begin m_st = wr ? 2 : 1; m_base = addr; m_cnt = 0; end
            else begin m_st = 0; mask = '0; end
        end else if (m_st == 1 || m_st == 2) begin
            m_cnt = m_cnt + {1'b0, ~step_n};
            m_st = wr ? 2 : 1;
        end else begin
            m_st = 0; mask = '0;
        end
        lo = order_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        a = {m_base[AW-1:2], lo};
        for (int i = 0; i < NB; i++)
            if (mask[i]) rmem[a][i*LW +: LW] = dq_i[i*LW +: LW];
        e.oe = (m_st == 1) && !oe_n && !sleep;
        e.data = rmem[a];
        e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_read(input logic [AW-1:0] a, input string tag);
        idle_inputs(); addr = a; start_host_n = 1'b0; tick(tag);
    endtask

    task automatic ctrl_write_all(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        idle_inputs(); addr = a; dq_i = d; start_ctrl_n = 1'b0; all_wr_n = 1'b0; tick(tag);
    endtask

    // Monitor: pops one expectation per clock and compares.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_chk++;
                if (dq_oe !== e.oe || (e.oe && dq_o !== e.data)) begin
                    n_fail++;
                    $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                             e.tag, dq_oe, dq_o, e.oe, e.data);
                end
            end
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0, "R13 oe low in reset", {31'b0, dq_oe}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R13 oe low after reset", {31'b0, dq_oe}, '0);

        // R9/R3: fill the array with all-lane writes from the controller strobe.
        for (int a = 0; a < DEPTH; a++)
            ctrl_write_all(a[AW-1:0], 32'hC0DE_0000 | (a * 32'h0101_0111), "R3 R9 fill");
        // R10/R2: new host address every cycle, no stall.
        for (int a = DEPTH - 1; a >= 0; a--) host_read(a[AW-1:0], "R2 R10 back-to-back read");

        // R8: every lane-select pattern on its own word, then read back.
        for (int m = 0; m < 16; m++) begin
            idle_inputs(); addr = m[AW-1:0]; dq_i = 32'h5A6B_7C8D ^ (m * 32'h1111_1111);
            start_ctrl_n = 1'b0; lane_wr_n = 1'b0; lane_sel_n = ~m[NB-1:0];
            tick("R8 lane write");
            host_read(m[AW-1:0], "R8 lane readback");
        end

        // R9: all-lane write overrides disabled lane controls.
        idle_inputs(); addr = 4'd6; dq_i = 32'hDEAD_BEEF; start_ctrl_n = 1'b0;
        all_wr_n = 1'b0; lane_wr_n = 1'b1; lane_sel_n = '1; tick("R9 override");
        host_read(4'd6, "R9 override readback");

        // R6: linear burst from offset 1, then R5 stall.
        idle_inputs(); order_lin = 1'b1; addr = 4'd5; start_host_n = 1'b0; tick("R6 linear beat0");
        for (int b = 1; b < 4; b++) begin idle_inputs(); step_n = 1'b0; tick("R6 linear beat"); end
        idle_inputs(); step_n = 1'b1; tick("R5 stall");
        idle_inputs(); tick("R5 stall again");
        idle_inputs(); step_n = 1'b0; tick("R5 resume wrap");

        // R7: interleaved burst from offset 1 and offset 3.
        order_lin = 1'b0;
        idle_inputs(); addr = 4'd9; start_host_n = 1'b0; tick("R7 interleaved beat0");
        for (int b = 1; b < 4; b++) begin idle_inputs(); step_n = 1'b0; tick("R7 interleaved beat"); end
        idle_inputs(); addr = 4'd15; start_host_n = 1'b0; tick("R7 interleaved start3");
        for (int b = 1; b < 4; b++) begin idle_inputs(); step_n = 1'b0; tick("R7 interleaved from3"); end
        order_lin = 1'b1;

        // R3/R6: write burst continuing with the step input, then read it back.
        ctrl_write_all(4'd10, 32'h1000_0001, "R3 burst write beat0");
        for (int b = 1; b < 4; b++) begin
            idle_inputs(); step_n = 1'b0; all_wr_n = 1'b0; dq_i = 32'h1000_0001 + b; tick("R3 burst write beat");
        end
        host_read(4'd8, "R3 write readback");
        for (int b = 1; b < 4; b++) begin idle_inputs(); step_n = 1'b0; tick("R3 readback beat"); end

        // R2: host strobe ignored while cs1_n is high; burst continues.
        host_read(4'd0, "R2 start");
        idle_inputs(); cs1_n = 1'b1; start_host_n = 1'b0; addr = 4'd12; step_n = 1'b0;
        tick("R2 host strobe ignored");

        // R4: both strobes with write controls: read, no write.
        idle_inputs(); addr = 4'd4; dq_i = 32'hBAD0_BAD0; start_host_n = 1'b0; start_ctrl_n = 1'b0;
        all_wr_n = 1'b0; tick("R4 host priority");
        host_read(4'd4, "R4 no write happened");

        // R1: deselect by cs2 or cs3_n.
        idle_inputs(); addr = 4'd3; start_ctrl_n = 1'b0; cs2 = 1'b0; tick("R1 deselect cs2");
        idle_inputs(); tick("R1 stays idle");
        idle_inputs(); addr = 4'd3; start_host_n = 1'b0; cs3_n = 1'b1; tick("R1 deselect cs3");

        // R11: output enable acts without a clock.
        host_read(4'd7, "R11 read");
        oe_n = 1'b1; #1;
        chk(dq_oe == 1'b0, "R11 async oe off", {31'b0, dq_oe}, '0);
        idle_inputs(); oe_n = 1'b1; tick("R11 oe held high");

        // R12: sleep blocks writes and drive, contents kept.
        host_read(4'd2, "R12 read before sleep");
        sleep = 1'b1; #1;
        chk(dq_oe == 1'b0, "R12 async sleep off", {31'b0, dq_oe}, '0);
        idle_inputs(); sleep = 1'b1; addr = 4'd2; dq_i = 32'h0; start_ctrl_n = 1'b0; all_wr_n = 1'b0;
        tick("R12 write during sleep");
        idle_inputs(); tick("R12 wake idle");
        host_read(4'd2, "R12 contents kept");

        idle_inputs(); tick("drain");
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule